// File: doc/BRIEF.md
# Carry-Skip Adder with Symmetric Block Profile

This block is a purely combinational adder of two WIDTH-bit operands and a carry-in. The operand is split into a chain of ripple-carry blocks. Each block forms its own group propagate (the AND of its per-bit XOR propagates). A 2:1 multiplexer then lets the carry that enters the block pass straight on to the next block whenever every bit of the block propagates. When any bit does not propagate, the multiplexer passes on the carry produced by the block's own ripple chain.

Block widths come from a profile parameter. The symmetric profile starts at BASE_W bits, grows by one bit per block up to the middle and mirrors back down. With the defaults this gives 3,4,5,6,6,5,4,3, which totals 36 bits. The uniform profile gives every block BASE_W bits. Elaboration stops with an error when the widths do not add up to WIDTH. The block sits in a datapath wherever a wide adder with a short carry path is wanted and no pipeline stage is allowed.

Top module: `csk_var_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of x + y + cin for every input combination.
- R2: `cout` equals bit WIDTH of x + y + cin, i.e. the carry out of the top bit.
- R3: When x XOR y is 1 in every bit of a block, the carry leaving that block equals the carry entering it. An operand pair whose propagate run covers several whole blocks delivers the carry across all of them: for example, 0x1_FFFF_FFFC + 0x0_0000_0004 gives 0x2_0000_0000 with cout 0.
- R4: With the symmetric profile the block widths are BASE_W, BASE_W+1, … up to the middle and then mirror back down. The defaults give 3,4,5,6,6,5,4,3 (block g starts at bits 0,3,7,12,18,24,29,33). The carry into every block boundary equals the true carry of the addition at that bit position.
- R5: With the uniform profile every block is BASE_W bits wide and NUM_BLK·BASE_W = WIDTH. A 32-bit instance with eight 4-bit blocks obeys R1 and R2.
- R6: The outputs depend only on the present inputs. A carry-producing input vector leaves no trace in the result of the vector applied after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Low WIDTH bits of the total |
| cout | output | 1 | Carry out of the top bit |

## Verification
Every result is due in the same cycle as its stimulus, because the path from input to output holds no register. The bench changes operands just after a rising clock edge and reads `sum` and `cout` at the following falling edge, half a period later, so each check sees only the settled response to its own vector. Vectors that run a propagate pattern over several whole blocks make the skip multiplexers, not the ripple chains, the carriers of the carry. A uniform-profile instance receives the same kind of vectors, and a walk of pseudo-random operands is compared against a behavioural sum.

// File: rtl/csk_pkg.sv
// Package: shared profile type and elaboration-time width arithmetic for
// the carry-skip adder. Assumes NUM_BLK >= 1 and BASE_W >= 1.
package csk_pkg;

    typedef enum logic [0:0] {
        PROF_SYMMETRIC = 1'b0,
        PROF_UNIFORM   = 1'b1
    } profile_e;

    // Width of block idx under the chosen profile.
    function automatic int unsigned blk_width(profile_e prof, int unsigned base,
                                              int unsigned nblk, int unsigned idx);
        int unsigned half;
        half = nblk / 2;
        if (prof == PROF_UNIFORM) begin
            return base;
        end
        if (idx < half) begin
            return base + idx;
        end
        return base + (nblk - 1 - idx);
    endfunction

    // Bit position where block idx starts (sum of all lower block widths).
    function automatic int unsigned blk_lo(profile_e prof, int unsigned base,
                                           int unsigned nblk, int unsigned idx);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < idx; j++) begin
            acc = acc + blk_width(prof, base, nblk, j);
        end
        return acc;
    endfunction

endpackage

// File: rtl/csk_full_adder.sv
// Module: one-bit full adder cell. Exposes the bit propagate so the block
// can form its group propagate. Purely combinational.
module csk_full_adder (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co,
    output logic p
);

    // Propagate, sum and carry of a single bit.
    always_comb begin
        p  = a ^ b;
        s  = p ^ ci;
        co = (a & b) | (p & ci);
    end

endmodule

// File: rtl/csk_ripple_block.sv
// Module: W-bit ripple-carry block. Chains full adders from its carry-in and
// reports both its rippled carry-out and its group propagate (AND of all
// bit propagates). Assumes W >= 1. Purely combinational.
module csk_ripple_block #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         rip_co,
    output logic         grp_p
);

    logic [W:0]   chain;
    logic [W-1:0] bit_p;

    assign chain[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_bit
        csk_full_adder u_fa (
            .a  (a[i]),
            .b  (b[i]),
            .ci (chain[i]),
            .s  (s[i]),
            .co (chain[i+1]),
            .p  (bit_p[i])
        );
    end

    // Block outputs: rippled carry and group propagate.
    always_comb begin
        rip_co = chain[W];
        grp_p  = &bit_p;
    end

endmodule

// File: rtl/csk_skip_mux.sv
// Module: skip selector between blocks. Forwards the block's incoming carry
// when the whole block propagates, otherwise its rippled carry. A selector
// (not an OR merge) keeps the result free of any start-at-zero assumption.
module csk_skip_mux (
    input  logic grp_p,
    input  logic blk_ci,
    input  logic rip_co,
    output logic blk_co
);

    // 2:1 selection on the group propagate.
    always_comb begin
        blk_co = grp_p ? blk_ci : rip_co;
    end

endmodule

// File: rtl/csk_var_adder.sv
// Module: WIDTH-bit carry-skip adder built from NUM_BLK ripple blocks whose
// widths follow PROFILE (symmetric grow-then-shrink, or uniform). Assumes
// the profile's widths sum to WIDTH; elaboration fails otherwise. No clock,
// no state: outputs follow inputs combinationally.
module csk_var_adder #(
    parameter int unsigned       WIDTH   = 36,
    parameter int unsigned       NUM_BLK = 8,
    parameter int unsigned       BASE_W  = 3,
    parameter csk_pkg::profile_e PROFILE = csk_pkg::PROF_SYMMETRIC
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int unsigned TOTAL_W = csk_pkg::blk_lo(PROFILE, BASE_W, NUM_BLK, NUM_BLK);

    if (TOTAL_W != WIDTH) begin : g_width_mismatch
        $error("csk_var_adder: block widths total %0d, WIDTH is %0d", TOTAL_W, WIDTH);
    end

    // Carry entering each block; entry NUM_BLK is the final carry-out.
    logic [NUM_BLK:0] blk_c;
    logic [NUM_BLK-1:0] blk_rip;
    logic [NUM_BLK-1:0] blk_p;

    assign blk_c[0] = cin;

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
        localparam int unsigned LO = csk_pkg::blk_lo(PROFILE, BASE_W, NUM_BLK, g);
        localparam int unsigned BW = csk_pkg::blk_width(PROFILE, BASE_W, NUM_BLK, g);

        csk_ripple_block #(.W(BW)) u_blk (
            .a      (x[LO +: BW]),
            .b      (y[LO +: BW]),
            .ci     (blk_c[g]),
            .s      (sum[LO +: BW]),
            .rip_co (blk_rip[g]),
            .grp_p  (blk_p[g])
        );

        csk_skip_mux u_skip (
            .grp_p  (blk_p[g]),
            .blk_ci (blk_c[g]),
            .rip_co (blk_rip[g]),
            .blk_co (blk_c[g+1])
        );
    end

    // Final carry-out taken from the last skip selector.
    always_comb begin
        cout = blk_c[NUM_BLK];
    end

endmodule

// File: rtl/csk_var_adder_chk.sv
// Module: assertion checker bound to csk_var_adder. Compares the adder's
// ports and block boundary carries against a reference sum formed here.
// Checks are skipped while any input is unknown.
module csk_var_adder_chk #(
    parameter int unsigned       WIDTH   = 36,
    parameter int unsigned       NUM_BLK = 8,
    parameter int unsigned       BASE_W  = 3,
    parameter csk_pkg::profile_e PROFILE = csk_pkg::PROF_SYMMETRIC
) (
    input logic [WIDTH-1:0]   x,
    input logic [WIDTH-1:0]   y,
    input logic               cin,
    input logic [WIDTH-1:0]   sum,
    input logic               cout,
    input logic [NUM_BLK:0]   blk_c
);

    logic [WIDTH:0] ref_full;
    logic [WIDTH:0] ref_carry;
    logic           known;

    // Reference total and the true carry into every bit position.
    always_comb begin
        known     = !$isunknown({x, y, cin});
        ref_full  = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
        ref_carry = ref_full ^ {1'b0, x} ^ {1'b0, y};
    end

    // Sum and carry-out against the reference.
    always_comb begin
        if (known) begin
            assert_sum_matches_R1: assert (sum == ref_full[WIDTH-1:0])
                else $error("sum mismatch");
            assert_cout_matches_R2: assert (cout == ref_full[WIDTH])
                else $error("cout mismatch");
        end
    end

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_skip_chk
        localparam int unsigned LO = csk_pkg::blk_lo(PROFILE, BASE_W, NUM_BLK, g);
        localparam int unsigned BW = csk_pkg::blk_width(PROFILE, BASE_W, NUM_BLK, g);
        // An all-propagate block hands its incoming carry straight on.
        always_comb begin
            if (known && (&(x[LO +: BW] ^ y[LO +: BW]))) begin
                assert_skip_passes_R3: assert (blk_c[g+1] == blk_c[g])
                    else $error("skip carry mismatch at block %0d", g);
            end
        end
    end

    for (genvar g = 0; g <= NUM_BLK; g++) begin : g_edge_chk
        localparam int unsigned LO = csk_pkg::blk_lo(PROFILE, BASE_W, NUM_BLK, g);
        // Carry at each block edge equals the true carry at that bit.
        always_comb begin
            if (known) begin
                assert_boundary_carry_R4: assert (blk_c[g] == ref_carry[LO])
                    else $error("boundary carry mismatch at edge %0d", g);
            end
        end
    end

endmodule

bind csk_var_adder csk_var_adder_chk #(
    .WIDTH   (WIDTH),
    .NUM_BLK (NUM_BLK),
    .BASE_W  (BASE_W),
    .PROFILE (PROFILE)
) u_chk (
    .x     (x),
    .y     (y),
    .cin   (cin),
    .sum   (sum),
    .cout  (cout),
    .blk_c (blk_c)
);

// File: tb/csk_var_adder_bench.sv
// Bench: table-driven and directed checks of the symmetric 36-bit adder,
// plus a uniform-profile 32-bit instance and a pseudo-random walk.
module csk_var_adder_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NV = 11;

    typedef struct packed {
        logic [35:0] a;
        logic [35:0] b;
        logic        ci;
        logic [35:0] s;
        logic        co;
    } vec_t;

    // Stimulus and expected results for the 36-bit symmetric instance.
    localparam vec_t VECS [NV] = '{
        '{36'h0_0000_0000, 36'h0_0000_0000, 1'b1, 36'h0_0000_0001, 1'b0},
        '{36'hF_FFFF_FFFF, 36'h0_0000_0000, 1'b1, 36'h0_0000_0000, 1'b1}, // R3 all blocks skip
        '{36'hA_AAAA_AAAA, 36'h5_5555_5555, 1'b0, 36'hF_FFFF_FFFF, 1'b0}, // R3
        '{36'hA_AAAA_AAAA, 36'h5_5555_5555, 1'b1, 36'h0_0000_0000, 1'b1}, // R3
        '{36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0, 36'hF_FFFF_FFFE, 1'b1},
        '{36'h8_0000_0000, 36'h8_0000_0000, 1'b0, 36'h0_0000_0000, 1'b1},
        '{36'h0_0000_0007, 36'h0_0000_0001, 1'b0, 36'h0_0000_0008, 1'b0}, // R4 block 0 edge
        '{36'h0_0000_007F, 36'h0_0000_0001, 1'b0, 36'h0_0000_0080, 1'b0}, // R4 skip block 1
        '{36'h1_2345_6789, 36'h0_FEDC_BA98, 1'b0, 36'h2_2222_2221, 1'b0},
        '{36'hF_0000_0000, 36'h1_0000_0000, 1'b0, 36'h0_0000_0000, 1'b1},
        '{36'h1_FFFF_FFFC, 36'h0_0000_0004, 1'b0, 36'h2_0000_0000, 1'b0}  // R3 blocks 1..6
    };

    logic        clk;
    logic        rst_n;
    logic [35:0] x36, y36, s36;
    logic        ci36, co36;
    logic [31:0] x32, y32, s32;
    logic        ci32, co32;
    int          errors;
    int          checks;

    csk_var_adder u_csk_var_adder (
        .x    (x36),
        .y    (y36),
        .cin  (ci36),
        .sum  (s36),
        .cout (co36)
    );

    csk_var_adder #(
        .WIDTH   (32),
        .NUM_BLK (8),
        .BASE_W  (4),
        .PROFILE (csk_pkg::PROF_UNIFORM)
    ) u_csk_var_adder_uni (
        .x    (x32),
        .y    (y32),
        .cin  (ci32),
        .sum  (s32),
        .cout (co32)
    );

    // Free-running bench clock used to pace stimulus and sampling.
    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // Drive after a rising edge, sample at the next falling edge.
    task automatic apply36(input logic [35:0] a, input logic [35:0] b, input logic c);
        @(posedge clk);
        #1;
        x36  = a;
        y36  = b;
        ci36 = c;
        @(negedge clk);
    endtask

    task automatic apply32(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(posedge clk);
        #1;
        x32  = a;
        y32  = b;
        ci32 = c;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: an overlong run is counted as a failure.
    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [36:0] ref36;
        logic [32:0] ref32;
        logic [31:0] lfsr;
        errors = 0;
        checks = 0;
        rst_n  = 1'b0;
        x36 = '0; y36 = '0; ci36 = 1'b0;
        x32 = '0; y32 = '0; ci32 = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // Reset state: zero operands give zero results (R1, R2).
        check("R1 reset sum", {28'd0, s36}, 64'd0);
        check("R2 reset cout", {63'd0, co36}, 64'd0);
        rst_n = 1'b1;

        // Table walk: R1 sum, R2 carry-out.
        for (int i = 0; i < NV; i++) begin
            apply36(VECS[i].a, VECS[i].b, VECS[i].ci);
            check("R1 table sum", {28'd0, s36}, {28'd0, VECS[i].s});
            check("R2 table cout", {63'd0, co36}, {63'd0, VECS[i].co});
        end

        // R6: a full-width carry followed by a killing vector leaves nothing stale.
        apply36(36'hF_FFFF_FFFF, 36'h0_0000_0000, 1'b1);
        apply36(36'hF_FFFF_FFFF, 36'h0_0000_0000, 1'b0);
        check("R6 no stale carry sum", {28'd0, s36}, {28'd0, 36'hF_FFFF_FFFF});
        check("R6 no stale carry cout", {63'd0, co36}, 64'd0);

        // R4: generate at the top bit of block 3 (bit 17) crosses into block 4.
        apply36(36'h0_0002_0000, 36'h0_0002_0000, 1'b0);
        check("R4 edge 17->18", {28'd0, s36}, {28'd0, 36'h0_0004_0000});

        // R5: uniform 4-bit blocks, 32 bits.
        apply32(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);
        check("R5 uniform skip sum", {32'd0, s32}, 64'd0);
        check("R5 uniform skip cout", {63'd0, co32}, 64'd1);
        apply32(32'h7FFF_FFF0, 32'h0000_0010, 1'b0);
        check("R5 uniform span sum", {32'd0, s32}, {32'd0, 32'h8000_0000});
        apply32(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        check("R5 uniform alt cout", {63'd0, co32}, 64'd1);

        // Pseudo-random walk against a behavioural sum (R1, R2, R5).
        lfsr = 32'h1ACE_B00C;
        for (int n = 0; n < 200; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            @(posedge clk);
            #1;
            x36  = {lfsr[3:0], lfsr};
            y36  = {lfsr[7:4], ~lfsr};
            ci36 = lfsr[5];
            x32  = lfsr;
            y32  = {lfsr[15:0], lfsr[31:16]};
            ci32 = lfsr[9];
            @(negedge clk);
            ref36 = {1'b0, x36} + {1'b0, y36} + {36'd0, ci36};
            ref32 = {1'b0, x32} + {1'b0, y32} + {32'd0, ci32};
            check("R1 random", {27'd0, co36, s36}, {27'd0, ref36});
            check("R5 random", {31'd0, co32, s32}, {31'd0, ref32});
        end

        finish_run();
    end

endmodule